// File: doc/BRIEF.md
# Read-During-Conversion Serial Output Port

This block is the converter-side serial output stage of an 18-bit successive-approximation converter. A host may fetch the result of the previous conversion while the next conversion is already running. The host lowers chip select and read, then supplies an external serial clock, and the block returns the held result one bit per clock pulse, most significant bit first. A small timer model stands in for the converter core. It raises `busy` on a start strobe, and when `busy` falls it hands over a new result word.

When a conversion ends, its result is copied into the output holding register and the bit pointer returns to the most significant bit. If the host has started a read but has not taken all bits by then, a one-cycle read-error pulse warns it that the word it was reading has been replaced. A read may also begin while the core is idle and run past the next start strobe. The remaining bits still come from the same held word. The serial input that a chained configuration would use is ignored.

The external serial clock is brought into the system clock domain through a synchronizer. Each rising serial clock edge advances the bit pointer a fixed number of system cycles later. The data bit is therefore steady both at the falling edge and just after the rising edge.

Top module: `adc_rdc_serial_port`

## Requirements
- R1: While reset is active, and after it is released, `busy`, `rd_error`, `sdo` and `sdo_oe` are all 0, and no result is waiting to be read.
- R2: `conv_start` high while `busy` is low raises `busy` at the next clock edge. `busy` then stays high for exactly CONV_CYCLES cycles. A `conv_start` that arrives while `busy` is high has no effect on the timing or on the captured word.
- R3: The word on `sample_in` when a conversion is accepted becomes the readable word in the cycle in which `busy` falls, and the bit pointer returns to the MSB at that edge.
- R4: While `cs_n` and `rd_n` are both low, `sdo` presents bit DATA_W-1-k of the held word after k counted pulses. A pulse is counted when the synchronized `sclk` shows a rising edge, which is SYNC_STAGES+1 system cycles after the rising edge at the port.
- R5: Once DATA_W pulses have been counted, further pulses do nothing and `sdo` is 0 until the next result is loaded.
- R6: If between 1 and DATA_W-1 bits have been counted when a conversion ends, `rd_error` is high for exactly one cycle, starting at the edge where `busy` falls.
- R7: No `rd_error` pulse occurs when no bit or all DATA_W bits of the held word have been counted at the end of a conversion.
- R8: A read that begins while `busy` is low may continue after a new `conv_start`. The remaining bits come from the same held word.
- R9: While `cs_n` or `rd_n` is high, `sdo` and `sdo_oe` are 0 and serial clock pulses are not counted.
- R10: `chain_in` has no effect on any output.
- R11: `sdo` does not change at a falling `sclk` edge while select, read and the conversion state are steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| sclk | input | 1 | External serial clock from the host |
| conv_start | input | 1 | Conversion start strobe |
| sample_in | input | DATA_W | Result word produced by the modelled conversion |
| chain_in | input | 1 | Chained serial input, unused in this mode |
| busy | output | 1 | Conversion in progress |
| sdo | output | 1 | Serial data, MSB first |
| sdo_oe | output | 1 | Serial data drive enable |
| rd_error | output | 1 | One-cycle pulse: read left unfinished when a conversion ended |

## Verification
The assertions rely on the host holding each level of `sclk` for at least four system cycles, so that a synchronized edge never overlaps the next port edge. The stimulus uses six-cycle half periods to respect this. They also rely on `cs_n` and `rd_n` changing only while `sclk` is low and not near a pulse. The bench tasks change select lines only between pulses, and they issue `conv_start` as a single-cycle strobe. The reference model follows the port-level timing only: a fixed synchronizer delay, the conversion length and the counted pulses.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  typedef enum logic [0:0] {
    CONV_IDLE = 1'b0,
    CONV_RUN  = 1'b1
  } conv_state_e;

  // Index of the bit to present after 'taken' bits have left the port.
  function automatic int unsigned msb_first_index(input int unsigned width,
                                                  input int unsigned taken);
    return width - 1 - taken;
  endfunction

endpackage

// File: rtl/adcrd_conv_timer.sv
module adcrd_conv_timer
  import adcrd_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int CONV_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);

  localparam int TW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(CONV_CYCLES - 1);

  conv_state_e       state_q, state_d;
  logic [TW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              accept;
  logic              cnt_en;

  assign accept = (state_q == CONV_IDLE) && start_i;
  assign done_o = (state_q == CONV_RUN) && (cnt_q == '0);
  assign busy_o = (state_q == CONV_RUN);
  assign result_o = word_q;
  assign cnt_en = accept || (state_q == CONV_RUN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    word_d  = word_q;
    unique case (state_q)
      CONV_IDLE: begin
        if (start_i) begin
          state_d = CONV_RUN;
          cnt_d   = LAST;
          word_d  = sample_i;
        end
      end
      CONV_RUN: begin
        if (cnt_q == '0) begin
          state_d = CONV_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = CONV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CONV_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (accept) begin
      word_q <= word_d;
    end
  end

endmodule

// File: rtl/adcrd_edge_sync.sv
module adcrd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  // STAGES flops for metastability, one more to find the edge
  logic [STAGES:0] chain_q;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      logic d;
      if (g == 0) begin : g_first
        assign d = async_i;
      end else begin : g_next
        assign d = chain_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[g] <= 1'b0;
        end else begin
          chain_q[g] <= d;
        end
      end
    end
  endgenerate

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/adcrd_out_shifter.sv
module adcrd_out_shifter
  import adcrd_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              step_i,
  input  logic              read_en_i,
  output logic              sdo_o,
  output logic              oe_o,
  output logic              err_o
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [DATA_W-1:0] hold_q, hold_d;
  logic [CNT_W-1:0]  taken_q, taken_d;
  logic              err_d;
  logic              err_q;
  logic              remaining;
  logic [CNT_W-1:0]  bit_idx;
  logic              hold_en;
  logic              taken_en;

  assign remaining = (taken_q < FULL);
  assign bit_idx   = CNT_W'(msb_first_index(DATA_W, 32'(taken_q)));
  assign hold_en   = load_i;
  assign taken_en  = load_i || (step_i && read_en_i && remaining);

  always_comb begin
    hold_d  = hold_q;
    taken_d = taken_q;
    err_d   = 1'b0;
    if (load_i) begin
      hold_d  = word_i;
      taken_d = '0;
      err_d   = (taken_q != '0) && remaining;
    end else if (step_i && read_en_i && remaining) begin
      taken_d = taken_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= FULL;
    end else if (taken_en) begin
      taken_q <= taken_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  always_comb begin
    sdo_o = 1'b0;
    if (read_en_i && remaining) begin
      sdo_o = hold_q[bit_idx];
    end
  end

  assign oe_o  = read_en_i;
  assign err_o = err_q;

endmodule

// File: rtl/adc_rdc_serial_port.sv
module adc_rdc_serial_port #(
  parameter int DATA_W      = 18,
  parameter int CONV_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              sclk,
  input  logic              conv_start,
  input  logic [DATA_W-1:0] sample_in,
  input  logic              chain_in,
  output logic              busy,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              rd_error
);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              conv_done;
  logic [DATA_W-1:0] conv_word;
  logic              sclk_rise;
  logic              read_en;
  logic              unused_chain_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign read_en = ~cs_n & ~rd_n;
  assign unused_chain_in = chain_in;

  adcrd_conv_timer #(
    .DATA_W     (DATA_W),
    .CONV_CYCLES(CONV_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (conv_start),
    .sample_i(sample_in),
    .busy_o  (busy),
    .done_o  (conv_done),
    .result_o(conv_word)
  );

  adcrd_edge_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sclk_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .async_i(sclk),
    .rise_o (sclk_rise)
  );

  adcrd_out_shifter #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_i   (conv_done),
    .word_i   (conv_word),
    .step_i   (sclk_rise),
    .read_en_i(read_en),
    .sdo_o    (sdo),
    .oe_o     (sdo_oe),
    .err_o    (rd_error)
  );

endmodule

// File: rtl/adc_rdc_serial_port_chk.sv
module adc_rdc_serial_port_chk (
  input logic clk,
  input logic rst_sync_n,
  input logic cs_n,
  input logic rd_n,
  input logic sclk,
  input logic conv_start,
  input logic busy,
  input logic sdo,
  input logic sdo_oe,
  input logic rd_error
);

  p_busy_rises_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (conv_start && !busy) |=> busy);

  p_err_at_busy_fall_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_error |-> (!busy && $past(busy)));

  p_err_single_cycle_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_error |=> !rd_error);

  p_deselected_quiet_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cs_n || rd_n) |-> (!sdo && !sdo_oe));

  p_sdo_steady_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($fell(sclk) && $stable(cs_n) && $stable(rd_n) && $stable(busy) && !rd_error)
      |-> $stable(sdo));

endmodule

bind adc_rdc_serial_port adc_rdc_serial_port_chk u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .cs_n      (cs_n),
  .rd_n      (rd_n),
  .sclk      (sclk),
  .conv_start(conv_start),
  .busy      (busy),
  .sdo       (sdo),
  .sdo_oe    (sdo_oe),
  .rd_error  (rd_error)
);

// File: tb/adc_rdc_serial_port_tb.sv
`timescale 1ns/1ps
module adc_rdc_serial_port_tb;

  localparam int W     = 18;
  localparam int CONV  = 300;
  localparam int HALF  = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic         rd_n = 1'b1;
  logic         sclk = 1'b0;
  logic         conv_start = 1'b0;
  logic [W-1:0] sample_in = '0;
  logic         chain_in = 1'b0;
  logic         busy, sdo, sdo_oe, rd_error;

  int n_checks = 0;
  int n_fail   = 0;
  int err_seen = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_rdc_serial_port #(.DATA_W(W), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .sclk(sclk),
    .conv_start(conv_start), .sample_in(sample_in), .chain_in(chain_in),
    .busy(busy), .sdo(sdo), .sdo_oe(sdo_oe), .rd_error(rd_error));

  // R10: chained input toggles pseudo-randomly during the whole run
  logic [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    chain_in <= lfsr[0];
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_rs1 = 0, m_rs2 = 0;
  int m_busy = 0, m_cnt = 0, m_cap = 0, m_hold = 0, m_taken = W, m_err = 0;
  int m_q[$] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0;
      m_busy = 0; m_cnt = 0; m_cap = 0; m_hold = 0; m_taken = W; m_err = 0;
      m_q = '{0, 0, 0};
    end else begin
      if (m_rs2 == 0) begin
        m_busy = 0; m_cnt = 0; m_cap = 0; m_hold = 0; m_taken = W; m_err = 0;
        m_q = '{0, 0, 0};
      end else begin
        bit done, rise, rd;
        done = (m_busy == 1) && (m_cnt == 0);
        rise = (m_q[1] == 1) && (m_q[2] == 0);
        rd   = !cs_n && !rd_n;
        m_err = (done && m_taken > 0 && m_taken < W) ? 1 : 0;
        if (done) begin
          m_hold = m_cap; m_taken = 0;
        end else if (rise && rd && m_taken < W) begin
          m_taken++;
        end
        if (m_busy == 1) begin
          if (m_cnt == 0) m_busy = 0; else m_cnt--;
        end else if (conv_start) begin
          m_busy = 1; m_cnt = CONV - 1; m_cap = int'(sample_in);
        end
        m_q.push_front(int'(sclk));
        void'(m_q.pop_back());
      end
      m_rs2 = m_rs1; m_rs1 = 1;
    end
  end

  // compare on every clock, away from the edges at which inputs move
  always @(posedge clk) begin
    #1;
    if (!finished) begin
      int e_sdo;
      e_sdo = (!cs_n && !rd_n && m_taken < W) ? ((m_hold >> (W - 1 - m_taken)) & 1) : 0;
      check("R2 busy", int'(busy), m_busy);
      check("R6/R7 rd_error", int'(rd_error), m_err);
      check("R4/R5/R9/R10 sdo", int'(sdo), e_sdo);
      check("R9 sdo_oe", int'(sdo_oe), int'(!cs_n && !rd_n));
      if (rd_error) err_seen++;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic start_conv(input logic [W-1:0] w);
    @(negedge clk); sample_in = w; conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
  endtask

  task automatic wait_fall();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic select(input logic c, input logic r);
    @(negedge clk); cs_n = c; rd_n = r;
    repeat (2) @(negedge clk);
  endtask

  // one pulse; sdo sampled just before the rising edge
  task automatic pulse(inout logic [W-1:0] acc);
    @(posedge clk); #1;
    acc = {acc[W-2:0], sdo};
    @(negedge clk); sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic read_bits(input int n, inout logic [W-1:0] acc);
    for (int i = 0; i < n; i++) pulse(acc);
  endtask

  localparam logic [W-1:0] W1 = 18'h2A5C3, W2 = 18'h1B3E7, W3 = 18'h30F0F,
                           W4 = 18'h0C3A5, W5 = 18'h25A5A, WX = 18'h3FFFF;

  initial begin
    logic [W-1:0] acc;
    int blen, e0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 busy", int'(busy), 0);
    check("R1 sdo", int'(sdo), 0);
    check("R1 rd_error", int'(rd_error), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 sdo_oe after release", int'(sdo_oe), 0);

    // R2: busy length
    start_conv(W1);
    blen = 0;
    while (busy) begin blen++; @(negedge clk); end
    check("R2 busy length", blen, CONV);

    // R3/R4/R5/R7: full read of the previous word during conversion
    e0 = err_seen;
    start_conv(W2);
    select(1'b0, 1'b0);
    acc = '0; read_bits(W, acc);
    check("R4 MSB-first word", int'(acc), int'(W1));
    acc = '0; read_bits(1, acc);
    check("R5 extra pulse gives 0", int'(acc[0]), 0);
    select(1'b1, 1'b1);
    wait_fall();
    repeat (2) @(negedge clk);
    check("R7 no error after full read", err_seen - e0, 0);

    // R6: truncated read
    e0 = err_seen;
    start_conv(W3);
    select(1'b0, 1'b0);
    acc = '0; read_bits(7, acc);
    check("R3 first 7 bits", int'(acc[6:0]), int'(W2[17:11]));
    select(1'b1, 1'b1);
    wait_fall();
    repeat (2) @(negedge clk);
    check("R6 one error pulse", err_seen - e0, 1);

    // R8: read begun while idle continues across a new start
    e0 = err_seen;
    select(1'b0, 1'b0);
    acc = '0; read_bits(10, acc);
    start_conv(W4);
    read_bits(8, acc);
    check("R8 word across start", int'(acc), int'(W3));
    select(1'b1, 1'b1);
    wait_fall();
    repeat (2) @(negedge clk);
    check("R7 no error across start", err_seen - e0, 0);

    // R9 and R2 ignore: deselected pulses, start while busy
    start_conv(W5);
    start_conv(WX);
    select(1'b1, 1'b0);
    acc = '1; read_bits(3, acc);
    check("R9 sdo 0 without cs", int'(acc[2:0]), 0);
    select(1'b0, 1'b1);
    acc = '1; read_bits(2, acc);
    check("R9 sdo 0 without rd", int'(acc[1:0]), 0);
    select(1'b0, 1'b0);
    acc = '0; read_bits(W, acc);
    check("R9 uncounted pulses, R10 chain ignored", int'(acc), int'(W4));
    select(1'b1, 1'b1);
    wait_fall();

    start_conv(W1);
    select(1'b0, 1'b0);
    acc = '0; read_bits(W, acc);
    check("R2 start while busy ignored", int'(acc), int'(W5));
    select(1'b1, 1'b1);
    wait_fall();
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    finished = 1'b1;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule